// File: doc/BRIEF.md
# Symmetric PWM Pair with Continuous Output Override

This block produces two pulse-width-modulated outputs from a single time base that counts up to a programmable period and then back down to zero. Each output has its own compare value. A compare value is written to a holding copy and reaches the working copy only when the counter is at zero. An action stage drives an output high when the counter meets its compare value on the way up, and low when it meets it on the way down. This gives centre-aligned pulses.

Above the action stage sits a continuous override with one field per output. The field can pin that output low or high for as long as it stays set. The override has its own holding copy, and a reload mode selects when a written value takes effect: at counter zero, at the period, at either, or at once. While an output is pinned, the counter, the compare matching and the action-stage state all keep running. When the pin is released, the output shows whatever level the action stage has reached by then. Single-cycle zero and period strobes come out of the block for interrupt and conversion-trigger logic.

Configuration goes through one write port with a small address map. The counter advances on every clock.

Top module: `pwmf_top`

## Requirements
- R1: While running, the counter steps by one each clock. When it counts up and is at or above the period, it turns to counting down. When it counts down and reaches 0, it turns to counting up. A period of 0 holds the counter at 0.
- R2: A write to address 6 clears the counter to 0 with the direction set to up, on the edge of the write.
- R3: A write to address 1 (compare A) or address 2 (compare B) fills only the holding copy. The working compare value takes the holding value on each clock edge where the block is running and the counter is 0.
- R4: Output A's action state goes to 1 on an edge where the counter equals working compare A while the direction is up. It goes to 0 on such an edge while the direction is down.
- R5: Output B follows the rule of R4 using working compare B.
- R6: The override register (address 3) holds output A's field in bits [1:0] and output B's field in bits [3:2]. For the active override, 01 drives the output low and 10 drives it high, ignoring the action state. 00 and 11 pass the action state through.
- R7: The reload mode (address 4, bits [1:0]) loads the override holding copy into the active override as follows: mode 0 on edges where the block runs at counter 0, mode 1 on edges at counter equal to the period, and mode 2 on either.
- R8: In reload mode 3, a write to address 3 reaches the active override on the edge of the write, so the output changes right after that edge.
- R9: The action state keeps following compare matches while an output is overridden. After release, the output equals that state.
- R10: The zero strobe is high while the block is running and the counter is 0. The period strobe is high while the block is running and the counter equals the period. Both keep running under override. For a non-zero period they are never high together.
- R11: Address 5 bit 0 is the run enable. While it is 0, the counter is frozen, no strobes fire, and no compare matches or boundary loads occur.
- R12: After reset the counter is 0 counting up, all registers are 0, the block is stopped, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 3 | Register address: 0 period, 1 compare A, 2 compare B, 3 override, 4 reload mode, 5 control, 6 counter clear |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| ev_zero | output | 1 | Counter-at-zero strobe |
| ev_prd | output | 1 | Counter-at-period strobe |

## Verification
The bench builds the block with CNT_W set to 8 and uses periods of 0, 5 and 6. These short periods let one run cover dozens of full up-down cycles. They also make every reload mode meet both its zero and its period boundary many times. Compare values are placed at 0, at the period and in between, which puts the set and clear edges right on the turning points. The bench drives override writes in every reload mode, a counter clear in the middle of a cycle, a pause, and a period of 0. A behavioural model checks both outputs and both strobes on every clock.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;
  localparam int ADDR_W = 3;
  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] A_PRD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_OVR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd6;

  typedef enum logic [1:0] {
    RL_ZERO = 2'd0, RL_PRD = 2'd1, RL_BOTH = 2'd2, RL_NOW = 2'd3
  } reload_e;

  // override field applied to an action state: 01 low, 10 high, else pass
  function automatic logic apply_override(input logic [1:0] fld, input logic q);
    case (fld)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return q;
    endcase
  endfunction
endpackage

// File: rtl/pwmf_timebase.sv
module pwmf_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic             at_zero,
  output logic             at_prd
);
  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c,
                                                input logic d, input logic [CNT_W-1:0] p);
    if (d) return (c >= p) ? ((p == '0) ? '0 : c - 1'b1) : c + 1'b1;
    return (c == '0) ? ((p == '0) ? '0 : CNT_W'(1)) : c - 1'b1;
  endfunction

  function automatic logic step_dir(input logic [CNT_W-1:0] c,
                                    input logic d, input logic [CNT_W-1:0] p);
    if (d) return !(c >= p);
    return (c == '0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (run) begin
      cnt <= step_cnt(cnt, up, prd);
      up  <= step_dir(cnt, up, prd);
    end
  end

  assign at_zero = run && (cnt == '0);
  assign at_prd  = run && (cnt == prd);

  AST_DIR_TURN: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && up && cnt >= prd && prd != '0) |=> !up); // R1
endmodule

// File: rtl/pwmf_channel.sv
module pwmf_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_shd,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             run,
  input  logic             at_zero,
  input  logic [CNT_W-1:0] cnt,
  input  logic             up,
  output logic             act_q
);
  logic [CNT_W-1:0] shd, act;
  logic             hit;

  assign hit = run && (cnt == act);

  always_ff @(posedge clk) begin
    if (rst) begin
      shd   <= '0;
      act   <= '0;
      act_q <= 1'b0;
    end else begin
      if (wr_shd)  shd <= wr_data;
      if (at_zero) act <= shd;
      if (hit)     act_q <= up;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> $stable(act)); // R3
  AST_QA_SET: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == act && up) |=> act_q); // R4
endmodule

// File: rtl/pwmf_override.sv
module pwmf_override
  import pwmf_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ovr,
  input  logic             wr_mode,
  input  logic [2*NCH-1:0] wr_data,
  input  logic             at_zero,
  input  logic             at_prd,
  output logic [2*NCH-1:0] ovr_act
);
  logic [2*NCH-1:0] ovr_shd;
  reload_e          mode;
  logic             bound_load;

  always_comb begin
    case (mode)
      RL_ZERO: bound_load = at_zero;
      RL_PRD:  bound_load = at_prd;
      RL_BOTH: bound_load = at_zero || at_prd;
      default: bound_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_shd <= '0;
      ovr_act <= '0;
      mode    <= RL_ZERO;
    end else begin
      if (wr_ovr)  ovr_shd <= wr_data;
      if (wr_mode) mode <= reload_e'(wr_data[1:0]);
      if (wr_ovr && mode == RL_NOW) ovr_act <= wr_data;
      else if (bound_load)          ovr_act <= ovr_shd;
    end
  end

  AST_FORCE_IMM: assert property (@(posedge clk) disable iff (rst)
    (wr_ovr && mode == RL_NOW) |=> (ovr_act == $past(wr_data))); // R8
endmodule

// File: rtl/pwmf_top.sv
module pwmf_top
  import pwmf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             ev_zero,
  output logic             ev_prd
);
  localparam int OVR_W = 2 * NCH;

  logic [CNT_W-1:0] prd, cnt;
  logic             run, up, at_zero, at_prd, clr;
  logic [NCH-1:0]   aq;
  logic [OVR_W-1:0] ovr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      prd <= '0;
      run <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_PRD)  prd <= wr_data;
      if (wr_addr == A_CTRL) run <= wr_data[0];
    end
  end

  assign clr = wr_en && (wr_addr == A_CLR);

  pwmf_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .run(run), .clr(clr), .prd(prd),
    .cnt(cnt), .up(up), .at_zero(at_zero), .at_prd(at_prd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwmf_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_shd(wr_en && (wr_addr == A_CMP0 + 3'(i))),
      .wr_data(wr_data), .run(run), .at_zero(at_zero),
      .cnt(cnt), .up(up), .act_q(aq[i])
    );
  end

  pwmf_override #(.NCH(NCH)) u_ovr (
    .clk(clk), .rst(rst),
    .wr_ovr(wr_en && (wr_addr == A_OVR)),
    .wr_mode(wr_en && (wr_addr == A_MODE)),
    .wr_data(wr_data[OVR_W-1:0]),
    .at_zero(at_zero), .at_prd(at_prd), .ovr_act(ovr_act)
  );

  assign pwm_a   = apply_override(ovr_act[1:0], aq[0]);
  assign pwm_b   = apply_override(ovr_act[3:2], aq[1]);
  assign ev_zero = at_zero;
  assign ev_prd  = at_prd;

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    (prd != '0) |-> !(ev_zero && ev_prd)); // R10
endmodule

// File: tb/sim_pwmf_top.sv
module sim_pwmf_top;
  localparam int W = 8;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic pwm_a, pwm_b, ev_zero, ev_prd;
  int checks = 0, errors = 0, cycles = 0;
  string tag = "R12";

  // reference model state
  int m_cnt, m_prd, m_sa, m_sb, m_aa, m_ab, m_fs, m_fa, m_mode;
  bit m_up, m_run, m_qa, m_qb, done = 0;

  pwmf_top #(.CNT_W(W)) u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .ev_zero(ev_zero), .ev_prd(ev_prd));

  always #10 clk = ~clk;

  function automatic bit ovr(int fld, bit q);
    if (fld == 1) return 0;
    if (fld == 2) return 1;
    return q;
  endfunction

  always @(posedge clk) begin
    bit z, p, ld;
    if (rst) begin
      m_cnt = 0; m_up = 1; m_prd = 0; m_sa = 0; m_sb = 0; m_aa = 0; m_ab = 0;
      m_fs = 0; m_fa = 0; m_mode = 0; m_run = 0; m_qa = 0; m_qb = 0;
    end else begin
      z = m_run && m_cnt == 0;
      p = m_run && m_cnt == m_prd;
      if (m_run && m_cnt == m_aa) m_qa = m_up;
      if (m_run && m_cnt == m_ab) m_qb = m_up;
      if (z) begin m_aa = m_sa; m_ab = m_sb; end
      ld = (m_mode == 0 && z) || (m_mode == 1 && p) || (m_mode == 2 && (z || p));
      if (wr_en && wr_addr == 3 && m_mode == 3) m_fa = wr_data & 15;
      else if (ld) m_fa = m_fs;
      if (wr_en && wr_addr == 6) begin m_cnt = 0; m_up = 1; end
      else if (m_run) begin
        if (m_up) begin
          if (m_cnt >= m_prd) begin m_up = 0; m_cnt = (m_prd == 0) ? 0 : m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_up = 1; m_cnt = (m_prd == 0) ? 0 : 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (wr_en) case (wr_addr)
        0: m_prd = wr_data;
        1: m_sa = wr_data;
        2: m_sb = wr_data;
        3: m_fs = wr_data & 15;
        4: m_mode = wr_data & 3;
        5: m_run = wr_data[0];
        default: ;
      endcase
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    cycles++;
    chk("pwm_a", pwm_a, ovr(m_fa & 3, m_qa));
    chk("pwm_b", pwm_b, ovr((m_fa >> 2) & 3, m_qb));
    chk("ev_zero", ev_zero, m_run && m_cnt == 0);
    chk("ev_prd", ev_prd, m_run && m_cnt == m_prd);
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    tag = "R12";
    chk("reset pwm_a", pwm_a, 0);
    chk("reset ev_zero", ev_zero, 0);
    tag = "R1";
    wr(0, 6); wr(1, 2); wr(2, 4); wr(5, 1);
    idle(40);
    tag = "R3"; wr(1, 5); wr(2, 0); idle(30);
    tag = "R4"; wr(1, 6); idle(30);
    tag = "R5"; wr(2, 3); idle(30);
    tag = "R8"; wr(4, 3); wr(3, 1 | (2 << 2));
    #1;
    chk("forced pwm_a right after write", pwm_a, 0);
    chk("forced pwm_b right after write", pwm_b, 1);
    tag = "R6"; idle(30);
    chk("held low pwm_a", pwm_a, 0);
    wr(3, 3 | (3 << 2)); idle(20);
    tag = "R9"; wr(3, 2); idle(5); wr(3, 0); idle(20);
    tag = "R7"; wr(4, 0); wr(3, 1 | (1 << 2)); idle(20);
    wr(4, 1); wr(3, 2 | (2 << 2)); idle(20);
    wr(4, 2); wr(3, 0); idle(20);
    tag = "R10"; wr(4, 3); wr(3, 1); wr(0, 5); idle(30); wr(3, 0);
    tag = "R2"; idle(3); wr(6, 0); idle(20);
    tag = "R11"; wr(5, 0); idle(10);
    chk("stopped ev_zero", ev_zero, 0);
    chk("stopped ev_prd", ev_prd, 0);
    wr(5, 1); idle(20);
    tag = "R1"; wr(0, 0); idle(10); wr(0, 6); wr(6, 0); idle(30);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule